// File: doc/BRIEF.md
# Grouped Channel Register Bank with Per-Group Power-Up Initialization

This block holds the byte-wide control and status storage for sixteen groups of paired processing channels. A single 11-bit address selects one of three areas: a 32-byte window for each of the 32 channels, one main control byte per group, and two standalone bytes (an interrupt FIFO location and a test location). Reads are requested with `rd_en` and return one cycle later with a valid strobe. Writes complete at the clock edge.

Each group's main control byte carries a power-up bit. A write that moves that bit from 0 to 1 starts that group's initialization, and no other group is touched. The initialization loads the group's 64 channel bytes from a default table parameter and emits a one-cycle coefficient-clear strobe. It then keeps the group busy until two frame markers have arrived on `frame_sync`. A pairing-mode field in the same byte can mark channel B of the group as carrying don't-care data.

Top module: `grpreg_bank`

## Requirements
- R1: Channel c (0..31) owns bytes c*0x20 to c*0x20+0x1F. Group g is channel 2g (unit A) plus channel 2g+1 (unit B), so its window is g*0x40 to g*0x40+0x3F. Group g's main control byte is at 0x400+g. The FIFO byte is at 0x410 and the test byte at 0x411. The FIFO and test bytes are plain read/write storage.
- R2: Reset is synchronous and active high. While reset is high, `rd_valid` stays 0 and the data output stays 0. After reset, every main control byte, the FIFO byte and the test byte read 0x00, and no group is busy. Channel bytes keep their contents through reset.
- R3: Addresses 0x412 to 0x7FF read as 0x00, and writes to them change no readable location.
- R4: A read request sampled at a clock edge shows `rd_valid`=1 and the addressed byte on `rd_data` during the following cycle. The byte is the value held before any write at that same edge.
- R5: Bit 0 of a main control byte is the power-up bit and drives `pwr_on[g]`. Initialization starts only on a write that changes this bit from 0 to 1. Writing 1 over a 1 starts nothing.
- R6: Initialization sets byte k (0..63) of the group's window to bits [8k+7:8k] of the default table parameter. Windows of other groups keep their contents.
- R7: `coef_clr[g]` is high for exactly the one cycle after the write that starts group g's initialization. Other bits of `coef_clr` stay low.
- R8: From the cycle after the starting write, `grp_busy[g]` is 1 and bit 7 of the group's main control byte reads 1. Both clear in the cycle after the second `frame_sync` pulse sampled after that write. Writes to bit 7 are ignored.
- R9: While a group is busy, writes to any byte of its 64-byte window are ignored.
- R10: Bits 2:1 of a main control byte are the pairing mode: 00 normal, 01 extended delay, 10 back-to-back, 11 reserved. In any nonzero mode, `chan_b_active[g]` is 0, unit B's window reads 0x00, and writes to it are ignored. Unit A is unaffected. Returning to mode 00 exposes unit B's stored bytes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 11 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| frame_sync | input | 1 | One-cycle frame marker |
| pwr_on | output | 16 | Power-up bit of each group |
| grp_busy | output | 16 | Group initialization in progress |
| coef_clr | output | 16 | One-cycle coefficient clear per group |
| chan_b_active | output | 16 | Unit B carries live data (mode 00) |

## Verification
The hardest situation to reach is a write to a busy group's window that falls between the two frame markers. From the ports it can only be distinguished from a normal write by reading the byte back after the busy period ends and finding the table default. The stimulus therefore writes a byte before power-up, starts initialization, writes again while busy, and releases the frames one at a time, sampling `grp_busy` after each. The bench runs a second sequence on another group's unit B window while that group is in a paired mode. When the mode returns to normal, the bytes must show the loaded defaults rather than the writes made while unit B was inactive. The bench overrides the default table with a non-zero pattern, so a missing load cannot pass as cleared storage.

// File: rtl/grpreg_pkg.sv
package grpreg_pkg;

    localparam int N_GROUPS    = 16;
    localparam int CH_PER_GRP  = 2;
    localparam int WIN_BYTES   = 32;
    localparam int DW          = 8;
    localparam int AW          = 11;
    localparam int INIT_FRAMES = 2;

    localparam int N_CH      = N_GROUPS * CH_PER_GRP;
    localparam int GRP_BYTES = WIN_BYTES * CH_PER_GRP;
    localparam int GRP_W     = $clog2(N_GROUPS);
    localparam int OFF_W     = $clog2(GRP_BYTES);
    localparam int WIN_W     = $clog2(WIN_BYTES);
    localparam int FCNT_W    = $clog2(INIT_FRAMES + 1);
    localparam int CHAN_TOP  = N_CH * WIN_BYTES;

    localparam logic [AW-1:0] CTRL_BASE = AW'(CHAN_TOP);
    localparam logic [AW-1:0] FIFO_ADDR = AW'(CHAN_TOP + N_GROUPS);
    localparam logic [AW-1:0] TEST_ADDR = AW'(CHAN_TOP + N_GROUPS + 1);

    localparam int PWUP_BIT = 0;
    localparam int BUSY_BIT = 7;

    typedef enum logic [2:0] {
        AREA_CHAN,
        AREA_CTRL,
        AREA_FIFO,
        AREA_TEST,
        AREA_NONE
    } area_e;

    typedef enum logic [1:0] {
        MODE_NORMAL    = 2'b00,
        MODE_EXT_DELAY = 2'b01,
        MODE_BACK2BACK = 2'b10,
        MODE_RESERVED  = 2'b11
    } pair_mode_e;

    typedef struct packed {
        area_e             area;
        logic [GRP_W-1:0]  grp;
        logic [OFF_W-1:0]  off;
        logic              unit_b;
    } decode_t;

    typedef struct packed {
        pair_mode_e mode;
        logic       pwup;
    } ctrl_view_t;

    function automatic decode_t decode_addr(input logic [AW-1:0] a);
        decode_t d;
        d.area   = AREA_NONE;
        d.grp    = '0;
        d.off    = a[OFF_W-1:0];
        d.unit_b = a[WIN_W];
        if (a < CTRL_BASE) begin
            d.area = AREA_CHAN;
            d.grp  = a[OFF_W +: GRP_W];
        end else if (a < CTRL_BASE + AW'(N_GROUPS)) begin
            d.area = AREA_CTRL;
            d.grp  = a[GRP_W-1:0];
        end else if (a == FIFO_ADDR) begin
            d.area = AREA_FIFO;
        end else if (a == TEST_ADDR) begin
            d.area = AREA_TEST;
        end
        return d;
    endfunction

    function automatic logic unit_b_live(input logic [1:0] mode_bits);
        return pair_mode_e'(mode_bits) == MODE_NORMAL;
    endfunction

endpackage

// File: rtl/grpreg_decode.sv
module grpreg_decode
    import grpreg_pkg::*;
(
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    always_comb begin
        dec = decode_addr(addr);
    end
endmodule

// File: rtl/grpreg_group_ctl.sv
module grpreg_group_ctl
    import grpreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wdata,
    input  logic          frame_sync,
    output logic [6:0]    ctrl_q,
    output logic          busy,
    output logic          clr_pulse,
    output logic          init_start
);
    logic [FCNT_W-1:0] frames_q;
    ctrl_view_t        cur;

    always_comb begin
        cur        = ctrl_view_t'(ctrl_q[2:0]);
        init_start = ctrl_we && wdata[PWUP_BIT] && !cur.pwup;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            busy      <= 1'b0;
            frames_q  <= '0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= init_start;
            if (ctrl_we) begin
                ctrl_q <= wdata[6:0];
            end
            if (init_start) begin
                busy     <= 1'b1;
                frames_q <= '0;
            end else if (busy && frame_sync) begin
                if (frames_q == FCNT_W'(INIT_FRAMES - 1)) begin
                    busy     <= 1'b0;
                    frames_q <= '0;
                end else begin
                    frames_q <= frames_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/grpreg_chan_store.sv
module grpreg_chan_store
    import grpreg_pkg::*;
#(
    parameter logic [GRP_BYTES*DW-1:0] DEF_TABLE = '0
) (
    input  logic                clk,
    input  logic                we,
    input  logic [GRP_W-1:0]    grp,
    input  logic [OFF_W-1:0]    off,
    input  logic [DW-1:0]       wdata,
    input  logic [N_GROUPS-1:0] init_start,
    output logic [DW-1:0]       rdata
);
    logic [DW-1:0] grp_rd [N_GROUPS];

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [DW-1:0] bytes_q [GRP_BYTES];

        always_ff @(posedge clk) begin
            if (init_start[g]) begin
                for (int k = 0; k < GRP_BYTES; k++) begin
                    bytes_q[k] <= DEF_TABLE[k*DW +: DW];
                end
            end else if (we && grp == GRP_W'(g)) begin
                bytes_q[off] <= wdata;
            end
        end

        assign grp_rd[g] = bytes_q[off];
    end

    assign rdata = grp_rd[grp];
endmodule

// File: rtl/grpreg_bank.sv
module grpreg_bank
    import grpreg_pkg::*;
#(
    parameter logic [GRP_BYTES*DW-1:0] DEF_TABLE = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       addr,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    output logic [DW-1:0]       rd_data,
    output logic                rd_valid,
    input  logic                frame_sync,
    output logic [N_GROUPS-1:0] pwr_on,
    output logic [N_GROUPS-1:0] grp_busy,
    output logic [N_GROUPS-1:0] coef_clr,
    output logic [N_GROUPS-1:0] chan_b_active
);
    decode_t             dec;
    logic [6:0]          ctrl_q [N_GROUPS];
    logic [N_GROUPS-1:0] init_start;
    logic [N_GROUPS-1:0] ctrl_we;
    logic [DW-1:0]       fifo_q;
    logic [DW-1:0]       test_q;
    logic [DW-1:0]       store_rd;
    logic                chan_we;
    logic                b_hidden;
    logic [DW-1:0]       rd_next;

    grpreg_decode u_dec (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_ctl
        assign ctrl_we[g] = wr_en && dec.area == AREA_CTRL && dec.grp == GRP_W'(g);

        grpreg_group_ctl u_ctl (
            .clk        (clk),
            .rst        (rst),
            .ctrl_we    (ctrl_we[g]),
            .wdata      (wr_data),
            .frame_sync (frame_sync),
            .ctrl_q     (ctrl_q[g]),
            .busy       (grp_busy[g]),
            .clr_pulse  (coef_clr[g]),
            .init_start (init_start[g])
        );

        assign pwr_on[g]        = ctrl_q[g][PWUP_BIT];
        assign chan_b_active[g] = unit_b_live(ctrl_q[g][2:1]);
    end

    always_comb begin
        b_hidden = dec.unit_b && !chan_b_active[dec.grp];
        chan_we  = wr_en && dec.area == AREA_CHAN && !grp_busy[dec.grp] && !b_hidden;
    end

    grpreg_chan_store #(
        .DEF_TABLE (DEF_TABLE)
    ) u_store (
        .clk        (clk),
        .we         (chan_we),
        .grp        (dec.grp),
        .off        (dec.off),
        .wdata      (wr_data),
        .init_start (init_start),
        .rdata      (store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_q <= '0;
            test_q <= '0;
        end else if (wr_en) begin
            if (dec.area == AREA_FIFO) fifo_q <= wr_data;
            if (dec.area == AREA_TEST) test_q <= wr_data;
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (dec.area)
            AREA_CHAN: rd_next = b_hidden ? '0 : store_rd;
            AREA_CTRL: rd_next = {grp_busy[dec.grp], ctrl_q[dec.grp]};
            AREA_FIFO: rd_next = fifo_q;
            AREA_TEST: rd_next = test_q;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_next : '0;
        end
    end
endmodule

// File: rtl/grpreg_checker.sv
module grpreg_checker
    import grpreg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                rd_en,
    input logic                rd_valid,
    input logic                frame_sync,
    input logic [N_GROUPS-1:0] pwr_on,
    input logic [N_GROUPS-1:0] grp_busy,
    input logic [N_GROUPS-1:0] coef_clr
);
    AST_RDV_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en)); // R4

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (coef_clr != '0) |=> ((coef_clr & $past(coef_clr)) == '0)); // R7

    AST_CLR_NEEDS_PWUP: assert property (@(posedge clk) disable iff (rst)
        (coef_clr & ~pwr_on) == '0); // R5

    AST_CLR_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (coef_clr & ~grp_busy) == '0); // R8

    AST_BUSY_ENDS_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ((~grp_busy & $past(grp_busy)) != '0)) |-> $past(frame_sync)); // R8
endmodule

bind grpreg_bank grpreg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .frame_sync (frame_sync),
    .pwr_on     (pwr_on),
    .grp_busy   (grp_busy),
    .coef_clr   (coef_clr)
);

// File: tb/tb_grpreg_bank.sv
module tb_grpreg_bank;
    import grpreg_pkg::*;

    function automatic logic [DW-1:0] tb_def(input int k);
        return DW'(k * 7) ^ 8'h5A;
    endfunction

    function automatic logic [GRP_BYTES*DW-1:0] build_def();
        logic [GRP_BYTES*DW-1:0] t;
        for (int k = 0; k < GRP_BYTES; k++) t[k*DW +: DW] = tb_def(k);
        return t;
    endfunction

    localparam logic [GRP_BYTES*DW-1:0] TB_DEF = build_def();

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst = 1'b1;
    logic [AW-1:0]       addr = '0;
    logic                wr_en = 1'b0;
    logic [DW-1:0]       wr_data = '0;
    logic                rd_en = 1'b0;
    logic [DW-1:0]       rd_data;
    logic                rd_valid;
    logic                frame_sync = 1'b0;
    logic [N_GROUPS-1:0] pwr_on, grp_busy, coef_clr, chan_b_active;

    grpreg_bank #(.DEF_TABLE(TB_DEF)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .frame_sync(frame_sync), .pwr_on(pwr_on), .grp_busy(grp_busy),
        .coef_clr(coef_clr), .chan_b_active(chan_b_active)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [DW-1:0] q_exp [$];
    string         q_tag [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rd_valid) begin
            if (q_exp.size() == 0) begin
                check("R4 unrequested read data", 1, 0);
            end else begin
                check(q_tag.pop_front(), 32'(rd_data), 32'(q_exp.pop_front()));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        q_exp.push_back(e); q_tag.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic frame();
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        rd_en = 1'b1;
        idle(3);
        check("R2 no valid during reset", 32'(rd_valid), 0);
        check("R2 data low during reset", 32'(rd_data), 0);
        rd_en = 1'b0;
        rst = 1'b0;
        idle(1);

        check("R2 busy clear", 32'(grp_busy), 0);
        rd(11'h400, 8'h00, "R2 ctrl0 reset");
        rd(11'h40F, 8'h00, "R2 ctrl15 reset");
        rd(11'h410, 8'h00, "R2 fifo reset");
        rd(11'h411, 8'h00, "R2 test reset");

        wr(11'h410, 8'hA5);
        wr(11'h411, 8'h3C);
        rd(11'h410, 8'hA5, "R1 fifo rw");
        rd(11'h411, 8'h3C, "R1 test rw");
        wr(11'h7FF, 8'hEE);
        wr(11'h412, 8'hEE);
        rd(11'h412, 8'h00, "R3 unmapped low");
        rd(11'h7FF, 8'h00, "R3 unmapped high");
        rd(11'h410, 8'hA5, "R3 fifo untouched");

        wr(11'h145, 8'h99);
        rd(11'h145, 8'h99, "R1 channel 10 window");
        wr(11'h3FF, 8'h42);
        rd(11'h3FF, 8'h42, "R1 last channel byte");
        wr(11'h0C5, 8'h10);
        rd(11'h0C5, 8'h10, "R1 group3 pre-init");

        wr(11'h403, 8'h01);
        check("R7 clr pulse group3", 32'(coef_clr), 32'h0008);
        check("R8 busy group3 only", 32'(grp_busy), 32'h0008);
        check("R5 pwr_on", 32'(pwr_on), 32'h0008);
        idle(1);
        check("R7 clr one cycle", 32'(coef_clr), 0);
        rd(11'h403, 8'h81, "R8 busy bit reads");
        wr(11'h0C5, 8'h77);
        rd(11'h0C5, tb_def(5), "R9 write ignored while busy");
        rd(11'h0E0, tb_def(32), "R6 unit B default");
        rd(11'h145, 8'h99, "R6 other group untouched");
        frame();
        check("R8 busy after one frame", 32'(grp_busy[3]), 1);
        idle(2);
        frame();
        check("R8 busy clears after second frame", 32'(grp_busy[3]), 0);
        rd(11'h403, 8'h01, "R8 busy bit cleared");

        wr(11'h0C5, 8'h77);
        rd(11'h0C5, 8'h77, "R9 write accepted after init");
        wr(11'h403, 8'h01);
        check("R5 no restart on 1 over 1", 32'(coef_clr), 0);
        rd(11'h0C5, 8'h77, "R5 contents kept");
        wr(11'h403, 8'h80);
        rd(11'h403, 8'h00, "R8 bit7 write ignored");
        wr(11'h403, 8'h01);
        check("R5 restart after 0", 32'(coef_clr), 32'h0008);
        frame(); frame();
        rd(11'h0C5, tb_def(5), "R6 reload on restart");

        wr(11'h0A3, 8'h44);
        rd(11'h0A3, 8'h44, "R10 unit B normal");
        wr(11'h402, 8'h03);
        check("R10 chan_b inactive", 32'(chan_b_active[2]), 0);
        check("R10 other groups active", 32'(chan_b_active[3]), 1);
        rd(11'h0A3, 8'h00, "R10 unit B reads zero");
        frame(); frame();
        wr(11'h0A3, 8'h66);
        wr(11'h083, 8'h11);
        rd(11'h083, 8'h11, "R10 unit A live");
        rd(11'h0A3, 8'h00, "R10 unit B hidden");
        wr(11'h402, 8'h05);
        rd(11'h0A3, 8'h00, "R10 back-to-back hides B");
        wr(11'h402, 8'h01);
        check("R10 chan_b back active", 32'(chan_b_active[2]), 1);
        rd(11'h0A3, tb_def(35), "R10 B write was ignored");

        wr(11'h0C6, 8'h55);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(11'h403, 8'h00, "R2 ctrl cleared");
        rd(11'h410, 8'h00, "R2 fifo cleared");
        rd(11'h0C6, 8'h55, "R2 channel kept");
        rd(11'h0C6, 8'h55, "R4 back-to-back reads");
        idle(2);

        check("R4 queue drained", 32'(q_exp.size()), 0);
        finish_run();
    end
endmodule